// File: doc/BRIEF.md
# Settable 24-Hour Alarm Clock

This block keeps the time of day in hours, minutes and seconds. A programmable prescaler divides the system clock down to a one-second tick. The time is shown as hh:mm on a four-digit, time-multiplexed seven-segment display. Pushbuttons set the running time and a separately stored alarm time. When the alarm is enabled and the running time reaches the alarm time, an indicator LED lights and stays lit until the alarm is switched off.

Every pushbutton passes through a two-flop synchroniser and a debouncer. The debouncer emits one single-cycle pulse for each accepted press. Button 0 is a held modifier, and button 1 and button 2 step the hour and minute fields.

The set mode is decoded from the held modifier and switch 0:
- MODE_RUN: the modifier is released.
- MODE_SET_TIME: the modifier is held and switch 0 is low.
- MODE_SET_ALARM: the modifier is held and switch 0 is high.

The alarm controller has three states:
- ALM_OFF goes to ALM_ARMED when the enable switch is high.
- ALM_ARMED goes to ALM_OFF when the enable switch is low.
- ALM_ARMED goes to ALM_RINGING when the time matches.
- ALM_RINGING goes to ALM_OFF when the enable switch is low.

The display scanner steps SCAN_D0, SCAN_D1, SCAN_D2, SCAN_D3 and then back to SCAN_D0, one step per scan tick.

Top module: `alarm_clock`

## Requirements
- R1: After reset the running time is 00:00:00, the alarm time is 00:00, the alarm LED is off and the display shows 00:00.
- R2: A press is accepted only after its synchronised level has stayed stable for DEB_CYCLES cycles. A pulse shorter than that has no effect. An accepted press produces exactly one increment, however long the button is held.
- R3: Seconds count 0..59 on each second tick. When seconds wrap, minutes advance. When minutes wrap from 59 to 00, hours advance. 23:59:59 is followed by 00:00:00.
- R4: In MODE_SET_TIME (pb_i[0] held, sw_i[0] low), a pb_i[1] press adds one hour and wraps 23 to 00. A pb_i[2] press adds one minute and wraps 59 to 00 without changing the hour. A minute press also clears the seconds and the prescaler, and a set press takes precedence over a second tick in the same cycle.
- R5: Presses on pb_i[1] or pb_i[2] while pb_i[0] is released change neither the time nor the alarm.
- R6: In MODE_SET_ALARM (pb_i[0] held, sw_i[0] high), the same presses step the alarm hours and minutes with the same wrap rules and leave the running time unchanged.
- R7: The display shows the alarm time when sw_i[0] is high and the running time otherwise. Digit enables are active low, and exactly one is low at any time. They step in the order digit 0, 1, 2, 3 and repeat, each held for SCAN_DIV cycles. Digit 3 shows hour tens, digit 2 hour units, digit 1 minute tens and digit 0 minute units.
- R8: Segment outputs are active low, with seg_n_o[0..6] driving segments a..g. The digits 0..9 use the patterns (g..a, lit = 1) 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F. The point seg_n_o[7] is lit on digit 2 only, as the hh:mm separator.
- R9: led_o[0] turns on when sw_i[1] is high and the running time equals the alarm time with seconds at zero. It stays on while sw_i[1] stays high and goes off once sw_i[1] is low. led_o[7:1] are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (50 MHz in the default configuration) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pb_i | input | 4 | Pushbuttons: 0 set modifier, 1 hour step, 2 minute step, 3 unused |
| sw_i | input | 8 | Switches: 0 alarm view/target, 1 alarm enable, others unused |
| dig_en_n_o | output | 4 | Active-low digit enables |
| seg_n_o | output | 8 | Active-low segments a..g and decimal point |
| led_o | output | 8 | Bit 0 alarm indicator, others held low |

## Verification
The assertions assume that the button and switch levels reach the counters only through the synchronisers. They also assume that set pulses arrive as isolated single-cycle events, so a set press and a second tick may meet in the same cycle, but two presses on one button can never arrive back to back. The stimulus keeps to this. Every button change is held for far more than DEB_CYCLES, except one deliberate short glitch. Switches change only at quiet moments. The timed checks are anchored to the last minute press, which clears the prescaler, and they sample the display half a second away from any tick, so a rollover never lands inside a display read.

// File: rtl/alarm_clock_pkg.sv
package alarm_clock_pkg;

    localparam int unsigned HOURS_PER_DAY = 24;
    localparam int unsigned MIN_PER_HOUR  = 60;
    localparam int unsigned SEC_PER_MIN   = 60;
    localparam int unsigned HOUR_W        = $clog2(HOURS_PER_DAY);
    localparam int unsigned MIN_W         = $clog2(MIN_PER_HOUR);
    localparam int unsigned SEC_W         = $clog2(SEC_PER_MIN);
    localparam int unsigned NUM_DIGITS    = 4;

    typedef struct packed {
        logic [HOUR_W-1:0] hh;
        logic [MIN_W-1:0]  mm;
    } hhmm_t;

    typedef enum logic [1:0] {
        MODE_RUN,
        MODE_SET_TIME,
        MODE_SET_ALARM
    } set_mode_e;

    typedef enum logic [1:0] {
        ALM_OFF,
        ALM_ARMED,
        ALM_RINGING
    } alarm_state_e;

    typedef enum logic [1:0] {
        SCAN_D0,
        SCAN_D1,
        SCAN_D2,
        SCAN_D3
    } scan_state_e;

    // Active-high segment pattern, bit 0 = a ... bit 6 = g.
    function automatic logic [6:0] seg_pattern(input logic [3:0] d);
        logic [6:0] p;
        unique case (d)
            4'd0: p = 7'h3F;
            4'd1: p = 7'h06;
            4'd2: p = 7'h5B;
            4'd3: p = 7'h4F;
            4'd4: p = 7'h66;
            4'd5: p = 7'h6D;
            4'd6: p = 7'h7D;
            4'd7: p = 7'h07;
            4'd8: p = 7'h7F;
            4'd9: p = 7'h6F;
            default: p = 7'h40;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ac_divider.sv
module ac_divider #(
    parameter int unsigned DIV = 50
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST) && !clr_i;

    AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R3

endmodule

// File: rtl/ac_btn_cond.sv
module ac_btn_cond #(
    parameter int unsigned DEB_CYCLES = 500_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic level_o,
    output logic pulse_o
);
    localparam int unsigned CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic          s1_q, s2_q;
    logic          stable_q;
    logic [CW-1:0] cnt_q;
    logic          accept;

    assign accept = (s2_q != stable_q) && (cnt_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_q     <= 1'b0;
            s2_q     <= 1'b0;
            stable_q <= 1'b0;
            cnt_q    <= '0;
            pulse_o  <= 1'b0;
        end else begin
            s1_q    <= raw_i;
            s2_q    <= s1_q;
            pulse_o <= accept && s2_q;
            if (s2_q == stable_q) begin
                cnt_q <= '0;
            end else if (accept) begin
                cnt_q    <= '0;
                stable_q <= s2_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level_o = stable_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o); // R2
    AST_PULSE_ON_PRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |-> level_o); // R2

endmodule

// File: rtl/ac_timekeeper.sv
module ac_timekeeper
    import alarm_clock_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sec_tick_i,
    input  set_mode_e        mode_i,
    input  logic             inc_hr_i,
    input  logic             inc_mn_i,
    output hhmm_t            cur_o,
    output logic [SEC_W-1:0] sec_o,
    output hhmm_t            alm_o,
    output logic             clr_presc_o
);
    localparam logic [HOUR_W-1:0] HH_LAST = HOUR_W'(HOURS_PER_DAY - 1);
    localparam logic [MIN_W-1:0]  MM_LAST = MIN_W'(MIN_PER_HOUR - 1);
    localparam logic [SEC_W-1:0]  SS_LAST = SEC_W'(SEC_PER_MIN - 1);

    hhmm_t            cur_q, alm_q;
    logic [SEC_W-1:0] sec_q;
    logic set_t_hr, set_t_mn, set_a_hr, set_a_mn;

    function automatic logic [HOUR_W-1:0] next_hh(input logic [HOUR_W-1:0] h);
        return (h == HH_LAST) ? '0 : h + 1'b1;
    endfunction

    function automatic logic [MIN_W-1:0] next_mm(input logic [MIN_W-1:0] m);
        return (m == MM_LAST) ? '0 : m + 1'b1;
    endfunction

    always_comb begin
        set_t_hr = 1'b0;
        set_t_mn = 1'b0;
        set_a_hr = 1'b0;
        set_a_mn = 1'b0;
        unique case (mode_i)
            MODE_SET_TIME: begin
                set_t_hr = inc_hr_i;
                set_t_mn = inc_mn_i;
            end
            MODE_SET_ALARM: begin
                set_a_hr = inc_hr_i;
                set_a_mn = inc_mn_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '0;
            sec_q <= '0;
        end else if (set_t_hr || set_t_mn) begin
            if (set_t_hr) cur_q.hh <= next_hh(cur_q.hh);
            if (set_t_mn) begin
                cur_q.mm <= next_mm(cur_q.mm);
                sec_q    <= '0;
            end
        end else if (sec_tick_i) begin
            if (sec_q == SS_LAST) begin
                sec_q <= '0;
                if (cur_q.mm == MM_LAST) begin
                    cur_q.mm <= '0;
                    cur_q.hh <= next_hh(cur_q.hh);
                end else begin
                    cur_q.mm <= cur_q.mm + 1'b1;
                end
            end else begin
                sec_q <= sec_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            alm_q <= '0;
        end else begin
            if (set_a_hr) alm_q.hh <= next_hh(alm_q.hh);
            if (set_a_mn) alm_q.mm <= next_mm(alm_q.mm);
        end
    end

    assign cur_o       = cur_q;
    assign sec_o       = sec_q;
    assign alm_o       = alm_q;
    assign clr_presc_o = set_t_mn;

    AST_FIELD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_q.hh <= HH_LAST && cur_q.mm <= MM_LAST && sec_q <= SS_LAST
        && alm_q.hh <= HH_LAST && alm_q.mm <= MM_LAST); // R3
    AST_DAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sec_tick_i && mode_i == MODE_RUN && cur_q.hh == HH_LAST
        && cur_q.mm == MM_LAST && sec_q == SS_LAST
        |=> cur_q == '0 && sec_q == '0); // R3
    AST_MIN_SET_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_t_mn && !set_t_hr |=> sec_q == '0 && $stable(cur_q.hh)); // R4
    AST_ALARM_SET_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_a_hr || set_a_mn) && !sec_tick_i |=> $stable(cur_q) && $stable(sec_q)); // R6
    AST_RUN_ALARM_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_i == MODE_RUN |=> $stable(alm_q)); // R5

endmodule

// File: rtl/ac_alarm_fsm.sv
module ac_alarm_fsm
    import alarm_clock_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  hhmm_t            cur_i,
    input  logic [SEC_W-1:0] sec_i,
    input  hhmm_t            alm_i,
    output logic             ring_o
);
    alarm_state_e state_q, state_d;
    logic match;

    assign match = (cur_i == alm_i) && (sec_i == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_OFF:     if (en_i) state_d = ALM_ARMED;
            ALM_ARMED:   if (!en_i) state_d = ALM_OFF;
                         else if (match) state_d = ALM_RINGING;
            ALM_RINGING: if (!en_i) state_d = ALM_OFF;
            default:     state_d = ALM_OFF;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ALM_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ALM_RINGING: ring_o = 1'b1;
            default:     ring_o = 1'b0;
        endcase
    end

    AST_RING_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ring_o && en_i |=> ring_o); // R9
    AST_RING_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !ring_o); // R9
    AST_RING_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ring_o) |-> $past(match) && $past(en_i)); // R9

endmodule

// File: rtl/ac_display.sv
module ac_display
    import alarm_clock_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  scan_tick_i,
    input  hhmm_t                 shown_i,
    output logic [NUM_DIGITS-1:0] dig_en_n_o,
    output logic [7:0]            seg_n_o
);
    scan_state_e state_q, state_d;
    logic [3:0]  digit_val;
    logic        dp_on;
    logic [3:0]  hh_t, hh_u, mm_t, mm_u;

    assign hh_t = 4'(shown_i.hh / 5'd10);
    assign hh_u = 4'(shown_i.hh % 5'd10);
    assign mm_t = 4'(shown_i.mm / 6'd10);
    assign mm_u = 4'(shown_i.mm % 6'd10);

    always_comb begin
        state_d = state_q;
        if (scan_tick_i) begin
            unique case (state_q)
                SCAN_D0: state_d = SCAN_D1;
                SCAN_D1: state_d = SCAN_D2;
                SCAN_D2: state_d = SCAN_D3;
                SCAN_D3: state_d = SCAN_D0;
                default: state_d = SCAN_D0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SCAN_D0;
        else         state_q <= state_d;
    end

    always_comb begin
        dp_on = 1'b0;
        unique case (state_q)
            SCAN_D0: begin dig_en_n_o = 4'b1110; digit_val = mm_u; end
            SCAN_D1: begin dig_en_n_o = 4'b1101; digit_val = mm_t; end
            SCAN_D2: begin dig_en_n_o = 4'b1011; digit_val = hh_u; dp_on = 1'b1; end
            SCAN_D3: begin dig_en_n_o = 4'b0111; digit_val = hh_t; end
            default: begin dig_en_n_o = 4'b1111; digit_val = 4'd0; end
        endcase
        seg_n_o = ~{dp_on, seg_pattern(digit_val)};
    end

    AST_ONE_DIGIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(~dig_en_n_o) == 1); // R7
    AST_SCAN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !scan_tick_i |=> $stable(dig_en_n_o)); // R7

endmodule

// File: rtl/alarm_clock.sv
module alarm_clock
    import alarm_clock_pkg::*;
#(
    parameter int unsigned SEC_DIV    = 50_000_000,
    parameter int unsigned SCAN_DIV   = 50_000,
    parameter int unsigned DEB_CYCLES = 500_000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [3:0] pb_i,
    input  logic [7:0] sw_i,
    output logic [3:0] dig_en_n_o,
    output logic [7:0] seg_n_o,
    output logic [7:0] led_o
);
    localparam int unsigned NUM_BTN = 3;
    localparam int unsigned NUM_SW  = 2;

    logic [NUM_BTN-1:0] btn_lvl, btn_pls;
    logic [NUM_SW-1:0]  sw_s1, sw_s2;
    logic               sec_tick, scan_tick, clr_presc, ring;
    set_mode_e          mode;
    hhmm_t              cur, alm, shown;
    logic [SEC_W-1:0]   sec;
    logic               unused_inputs;

    for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
        ac_btn_cond #(.DEB_CYCLES(DEB_CYCLES)) u_btn (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .raw_i   (pb_i[b]),
            .level_o (btn_lvl[b]),
            .pulse_o (btn_pls[b])
        );
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sw_s1 <= '0;
            sw_s2 <= '0;
        end else begin
            sw_s1 <= sw_i[NUM_SW-1:0];
            sw_s2 <= sw_s1;
        end
    end

    always_comb begin
        if (!btn_lvl[0])  mode = MODE_RUN;
        else if (sw_s2[0]) mode = MODE_SET_ALARM;
        else              mode = MODE_SET_TIME;
    end

    ac_divider #(.DIV(SEC_DIV)) u_sec_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_presc),
        .tick_o (sec_tick)
    );

    ac_divider #(.DIV(SCAN_DIV)) u_scan_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (1'b0),
        .tick_o (scan_tick)
    );

    ac_timekeeper u_time (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sec_tick_i  (sec_tick),
        .mode_i      (mode),
        .inc_hr_i    (btn_pls[1]),
        .inc_mn_i    (btn_pls[2]),
        .cur_o       (cur),
        .sec_o       (sec),
        .alm_o       (alm),
        .clr_presc_o (clr_presc)
    );

    ac_alarm_fsm u_alarm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (sw_s2[1]),
        .cur_i  (cur),
        .sec_i  (sec),
        .alm_i  (alm),
        .ring_o (ring)
    );

    assign shown = sw_s2[0] ? alm : cur;

    ac_display u_disp (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .scan_tick_i (scan_tick),
        .shown_i     (shown),
        .dig_en_n_o  (dig_en_n_o),
        .seg_n_o     (seg_n_o)
    );

    assign led_o = {7'b0, ring};

    assign unused_inputs = ^{pb_i[3], sw_i[7:NUM_SW], btn_lvl[2:1], btn_pls[0]};

endmodule

// File: tb/tb_alarm_clock.sv
module tb_alarm_clock;
    localparam int DEB  = 4;
    localparam int SDIV = 64;
    localparam int SCAN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pb = '0;
    logic [7:0] sw = '0;
    logic [3:0] dig_en_n;
    logic [7:0] seg_n;
    logic [7:0] led;

    longint cyc = 0;
    longint anchor = 0;
    longint t0 = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    alarm_clock #(.SEC_DIV(SDIV), .SCAN_DIV(SCAN), .DEB_CYCLES(DEB)) dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .pb_i       (pb),
        .sw_i       (sw),
        .dig_en_n_o (dig_en_n),
        .seg_n_o    (seg_n),
        .led_o      (led)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int dec7(input logic [6:0] p);
        case (p)
            7'h3F: return 0;
            7'h06: return 1;
            7'h5B: return 2;
            7'h4F: return 3;
            7'h66: return 4;
            7'h6D: return 5;
            7'h7D: return 6;
            7'h07: return 7;
            7'h7F: return 8;
            7'h6F: return 9;
            default: return -1;
        endcase
    endfunction

    task automatic read_disp(output int val, output int bad);
        int d[4];
        bad = 0;
        for (int k = 0; k < 4; k++) d[k] = -1;
        for (int k = 0; k < 8 * SCAN; k++) begin
            int idx;
            int cnt;
            @(negedge clk);
            idx = -1;
            cnt = 0;
            for (int j = 0; j < 4; j++) begin
                if (!dig_en_n[j]) begin
                    cnt++;
                    idx = j;
                end
            end
            if (cnt != 1) begin
                bad++;
            end else begin
                d[idx] = dec7(~seg_n[6:0]);
                if (d[idx] < 0) bad++;
                if (seg_n[7] != ((idx == 2) ? 1'b0 : 1'b1)) bad++;
            end
        end
        for (int k = 0; k < 4; k++) if (d[k] < 0) bad++;
        val = d[3] * 1000 + d[2] * 100 + d[1] * 10 + d[0];
    endtask

    task automatic check_disp(input int exp, input string req);
        int val;
        int bad;
        read_disp(val, bad);
        chk(bad == 0, "R8", "segment/point encoding errors", bad, 0);
        chk(val == exp, req, "display hhmm", val, exp);
    endtask

    task automatic check_scan();
        int prev = -1;
        int run = 0;
        int bad = 0;
        bit first = 1'b1;
        for (int k = 0; k < 12 * SCAN; k++) begin
            int cur_d;
            @(negedge clk);
            cur_d = -1;
            for (int j = 0; j < 4; j++) if (!dig_en_n[j]) cur_d = j;
            if (cur_d == prev) begin
                run++;
            end else begin
                if (prev >= 0) begin
                    if (cur_d != (prev + 1) % 4) bad++;
                    if (!first && run != SCAN) bad++;
                    first = 1'b0;
                end
                prev = cur_d;
                run = 1;
            end
        end
        chk(bad == 0, "R7", "scan order and dwell errors", bad, 0);
    endtask

    task automatic press(input int idx, input int hold);
        @(negedge clk);
        pb[idx] = 1'b1;
        anchor = cyc;
        repeat (hold) @(negedge clk);
        pb[idx] = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic wait_to(input longint t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", 200000, 200000);
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk(led == 8'h00, "R1", "led after reset", int'(led), 0);
        check_disp(0, "R1");
        check_scan();

        // R5 steps without the modifier are ignored
        press(1, 12);
        press(2, 12);
        check_disp(0, "R5");
        sw[0] = 1'b1;
        repeat (10) @(negedge clk);
        check_disp(0, "R5");
        sw[0] = 1'b0;
        repeat (10) @(negedge clk);

        // R2 short glitch rejected, long hold gives one step
        pb[0] = 1'b1;
        repeat (12) @(negedge clk);
        @(negedge clk);
        pb[2] = 1'b1;
        repeat (2) @(negedge clk);
        pb[2] = 1'b0;
        repeat (12) @(negedge clk);
        check_disp(0, "R2");

        // R4 minute sweep, wraps 59 -> 00 without hour carry
        for (int i = 1; i <= 60; i++) begin
            press(2, (i == 1) ? 60 : 12);
            check_disp(i % 60, (i == 1) ? "R2" : "R4");
        end

        // R4 hour sweep, wraps 23 -> 00
        for (int i = 1; i <= 24; i++) begin
            press(1, 12);
            check_disp((i % 24) * 100, "R4");
        end
        for (int i = 1; i <= 23; i++) press(1, 12);
        check_disp(2300, "R4");
        for (int i = 1; i <= 59; i++) press(2, 12);
        t0 = anchor;
        check_disp(2359, "R4");
        pb[0] = 1'b0;

        // R3 run and roll over the day
        wait_to(t0 + 30 * SDIV + SDIV / 2);
        check_disp(2359, "R3");
        wait_to(t0 + 60 * SDIV + SDIV / 2);
        check_disp(0, "R3");

        // R6 alarm setting, running time untouched
        sw[0] = 1'b1;
        repeat (10) @(negedge clk);
        check_disp(0, "R1");
        pb[0] = 1'b1;
        repeat (12) @(negedge clk);
        press(2, 12);
        pb[0] = 1'b0;
        repeat (12) @(negedge clk);
        check_disp(1, "R6");
        sw[0] = 1'b0;
        repeat (10) @(negedge clk);
        check_disp(0, "R6");

        // R9 alarm match, hold and clear
        sw[1] = 1'b1;
        wait_to(t0 + 119 * SDIV + SDIV / 2);
        chk(led[0] == 1'b0, "R9", "led before match", int'(led[0]), 0);
        wait_to(t0 + 120 * SDIV + SDIV / 2);
        chk(led[0] == 1'b1, "R9", "led at match", int'(led[0]), 1);
        wait_to(t0 + 125 * SDIV + SDIV / 2);
        chk(led[0] == 1'b1, "R9", "led held while enabled", int'(led[0]), 1);
        chk(led[7:1] == 7'h00, "R9", "upper leds", int'(led[7:1]), 0);
        check_disp(1, "R3");
        sw[1] = 1'b0;
        repeat (10) @(negedge clk);
        chk(led[0] == 1'b0, "R9", "led after disable", int'(led[0]), 0);

        summary();
        $finish;
    end

endmodule